// File: doc/BRIEF.md
# Logarithmic I/Q Sample Codec

This block packs pairs of signed fixed-point I and Q samples into 16-bit logarithmic codes and unpacks such codes back into linear samples. Each sample is a two's complement Q1.15 value in the range -1 to +1. Its magnitude is expressed as attenuation below full scale, in units of 1/256 of a decibel-like step. The attenuation is formed as three times the negative base-2 logarithm, which approximates decibels. The sign travels as the top bit of the code. Because the magnitude lives in the log domain, a gain change is a plain addition to the 15-bit field. The compressor takes a signed gain offset with every pair and applies it with saturation.

The compressor finds the leading one of the magnitude, which gives the integer part of log2. It takes the eight bits below the leading one as a linear estimate of the fractional part. It then multiplies by three with a shift and an add. The expander divides the field by three through a reciprocal constant. It splits the quotient into whole and fractional octaves, rebuilds the mantissa with the same linear rule, and shifts it down. Both directions are four-stage pipelines behind valid/ready streams and accept one I/Q pair per cycle. The two lanes of a pair never interact.

Top module: `logiq_codec`

## Requirements
- R1: Bit 15 of each compressor code is 1 exactly when the input sample is negative; a zero sample gives bit 15 equal to 0.
- R2: For a non-zero sample with gain 0, let A be its magnitude, P the index of its highest set bit (0..14), and F the 8 bits directly below that bit, zero-filled on the right when P < 8. Then code bits 14:0 equal 3*((15-P)*256 - F).
- R3: The input 0x8000 (-1.0) is handled as magnitude 0x7FFF, so its code is 0x8003.
- R4: A zero sample gives code 0x7FFF (sign 0, field all ones), whatever the gain.
- R5: With a signed 16-bit gain G, the field of a non-zero sample is the R2 value plus G, clamped to 0 below and to 0x7FFF above; the sign bit is not changed by the gain.
- R6: The I and Q lanes are coded independently: each output depends only on its own lane's input and the shared gain.
- R7: The expander maps field 0x7FFF to 0. Any other field D gives L = floor(D/3), N = L>>8, M = L&255 and magnitude ((512-M)*64)>>N, capped at 32767. The output is the magnitude negated when bit 15 is set.
- R8: With gain 0, expanding the code of any sample returns the sample with every magnitude bit more than 8 places below its leading one cleared; -1.0 returns -32704 and 0 returns 0.
- R9: With the output ready, a pair accepted at a rising clock edge appears on the outputs after the third rising edge that follows it.
- R10: Each direction raises its in_ready exactly when its out_valid is low or its out_ready is high; while out_valid is high and out_ready low, the output word holds. Pairs leave in the order they entered, none lost or repeated.
- R11: While rst_n is low, both out_valid outputs are low, and they stay low after release until a pair has passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_in_valid | input | 1 | Compressor input pair valid |
| enc_in_ready | output | 1 | Compressor can take a pair this cycle |
| enc_in_i | input | 16 | I sample, Q1.15 two's complement |
| enc_in_q | input | 16 | Q sample, Q1.15 two's complement |
| enc_gain | input | 16 | Signed gain offset in field units, sampled with the pair |
| enc_out_valid | output | 1 | Compressor output pair valid |
| enc_out_ready | input | 1 | Consumer takes the compressed pair |
| enc_out_i | output | 16 | I code: sign, then 15-bit attenuation field |
| enc_out_q | output | 16 | Q code: sign, then 15-bit attenuation field |
| dec_in_valid | input | 1 | Expander input pair valid |
| dec_in_ready | output | 1 | Expander can take a pair this cycle |
| dec_in_i | input | 16 | I code |
| dec_in_q | input | 16 | Q code |
| dec_out_valid | output | 1 | Expander output pair valid |
| dec_out_ready | input | 1 | Consumer takes the expanded pair |
| dec_out_i | output | 16 | I sample, Q1.15 |
| dec_out_q | output | 16 | Q sample, Q1.15 |

## Verification
A stalled output and a newly offered pair can land in the same cycle. When the last stage is full and out_ready drops, the pair at the input must be refused in that very cycle while the held word stays put. Random out_ready patterns over random pairs provoke this case, and the scoreboard judges it by order and value against the arithmetic model. In a separate way, the zero-sample rule and gain clamping share the final compressor stage; a sweep that places zero samples among extreme positive and negative gains checks that the all-ones field wins.

// File: rtl/logiq_pkg.sv
package logiq_pkg;
  localparam int LQ_SAMPLE_W = 16;  // Q1.15 samples and 16-bit codes
  localparam int LQ_FRAC_W   = 8;   // fractional bits of the log field
  localparam int LQ_STAGES   = 4;   // register stages per direction
  localparam int LQ_LANES    = 2;   // I and Q

  typedef enum int {LANE_I = 0, LANE_Q = 1} lane_e;
endpackage

// File: rtl/logiq_pipe_ctrl.sv
module logiq_pipe_ctrl #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [STAGES-1:0] load
);
  logic [STAGES-1:0] vld_q;
  logic [STAGES-1:0] vld_d;
  logic              adv;

  // The whole pipe moves together unless the last stage is blocked.
  always_comb begin
    adv   = !vld_q[STAGES-1] || out_ready;
    vld_d = vld_q;
    if (adv) begin
      vld_d = {vld_q[STAGES-2:0], in_valid};
    end
    load = {vld_q[STAGES-2:0], in_valid} & {STAGES{adv}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign in_ready  = adv;
  assign out_valid = vld_q[STAGES-1];
endmodule

// File: rtl/logiq_enc_lane.sv
module logiq_enc_lane
  import logiq_pkg::*;
#(
  parameter int SW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic [LQ_STAGES-1:0] load,
  input  logic [SW-1:0]        smp,
  input  logic [SW-1:0]        gain,
  output logic [SW-1:0]        code
);
  localparam int MW = SW - 1;           // magnitude / field width
  localparam int PW = $clog2(SW - 1);   // leading-one index width
  localparam int LW = $clog2(SW) + FW;  // -log2 value, whole.frac

  // stage 1: sign and magnitude
  logic          s1_sgn_d, s1_sgn_q;
  logic [MW-1:0] s1_mag_d, s1_mag_q;
  logic [SW-1:0] s1_gain_q;
  logic [SW-1:0] neg;

  always_comb begin
    neg      = '0 - smp;
    s1_sgn_d = smp[SW-1];
    if (smp == {1'b1, {MW{1'b0}}}) begin
      s1_mag_d = '1;                    // -1.0 saturates
    end else if (smp[SW-1]) begin
      s1_mag_d = neg[MW-1:0];
    end else begin
      s1_mag_d = smp[MW-1:0];
    end
  end

  // stage 2: leading one, fraction, -log2
  logic [PW-1:0] lead;
  logic [MW-1:0] norm;
  logic [FW-1:0] frac;
  logic [LW-1:0] whole;
  logic [LW-1:0] s2_log_d, s2_log_q;
  logic          s2_zero_d, s2_zero_q;
  logic          s2_sgn_q;
  logic [SW-1:0] s2_gain_q;

  always_comb begin
    lead = '0;
    for (int b = 0; b < MW; b++) begin
      if (s1_mag_q[b]) lead = PW'(b);
    end
    s2_zero_d = (s1_mag_q == '0);
    norm      = s1_mag_q << (PW'(MW - 1) - lead);
    frac      = FW'(norm >> (MW - 1 - FW));
    whole     = LW'(MW) - LW'(lead);
    s2_log_d  = (whole << FW) - LW'(frac);
  end

  // stage 3: times three by shift and add
  logic [MW-1:0] s3_db_d, s3_db_q;
  logic          s3_zero_q, s3_sgn_q;
  logic [SW-1:0] s3_gain_q;

  always_comb begin
    s3_db_d = MW'({s2_log_q, 1'b0}) + MW'(s2_log_q);
  end

  // stage 4: gain with clamping, code assembly
  logic signed [MW+1:0] sum;
  logic [MW-1:0]        fld;
  logic [SW-1:0]        code_d, code_q;

  always_comb begin
    sum = $signed({2'b00, s3_db_q}) + $signed({s3_gain_q[SW-1], s3_gain_q});
    if (s3_zero_q) begin
      fld = '1;
    end else if (sum[MW+1]) begin
      fld = '0;
    end else if (sum[MW]) begin
      fld = '1;
    end else begin
      fld = sum[MW-1:0];
    end
    code_d = {s3_sgn_q, fld};
  end

  always_ff @(posedge clk) begin
    if (load[0]) begin
      s1_sgn_q  <= s1_sgn_d;
      s1_mag_q  <= s1_mag_d;
      s1_gain_q <= gain;
    end
    if (load[1]) begin
      s2_log_q  <= s2_log_d;
      s2_zero_q <= s2_zero_d;
      s2_sgn_q  <= s1_sgn_q;
      s2_gain_q <= s1_gain_q;
    end
    if (load[2]) begin
      s3_db_q   <= s3_db_d;
      s3_zero_q <= s2_zero_q;
      s3_sgn_q  <= s2_sgn_q;
      s3_gain_q <= s2_gain_q;
    end
    if (load[3]) begin
      code_q <= code_d;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/logiq_dec_lane.sv
module logiq_dec_lane
  import logiq_pkg::*;
#(
  parameter int SW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic [LQ_STAGES-1:0] load,
  input  logic [SW-1:0]        code,
  output logic [SW-1:0]        smp
);
  localparam int MW  = SW - 1;
  localparam int RSH = MW + 1;               // reciprocal scaling shift
  localparam int LW  = 2 * MW - RSH;         // quotient width
  localparam int NW  = LW - FW;              // whole-octave width
  localparam logic [MW-1:0] RCP = MW'((1 << RSH) / 3 + 1);

  // stage 1: capture
  logic          s1_sgn_q, s1_zero_q;
  logic [MW-1:0] s1_fld_q;

  // stage 2: divide by three through the reciprocal
  logic [2*MW-1:0] prod;
  logic [LW-1:0]   s2_log_d, s2_log_q;
  logic            s2_sgn_q, s2_zero_q;

  always_comb begin
    prod     = (2 * MW)'(s1_fld_q) * (2 * MW)'(RCP);
    s2_log_d = LW'(prod >> RSH);
  end

  // stage 3: rebuild mantissa, split octaves
  logic [NW-1:0]   s3_oct_d, s3_oct_q;
  logic [FW+1:0]   mant;
  logic [SW-1:0]   s3_man_d, s3_man_q;
  logic            s3_sgn_q, s3_zero_q;

  always_comb begin
    s3_oct_d = s2_log_q[LW-1:FW];
    mant     = (FW + 2)'(1 << (FW + 1)) - (FW + 2)'(s2_log_q[FW-1:0]);
    s3_man_d = SW'(mant) << (SW - 2 - FW);
  end

  // stage 4: shift down, saturate, apply sign
  logic [SW-1:0] shifted;
  logic [SW-1:0] mag;
  logic [SW-1:0] smp_d, smp_q;

  always_comb begin
    shifted = s3_man_q >> s3_oct_q;
    if (s3_zero_q) begin
      mag = '0;
    end else if (shifted[SW-1]) begin
      mag = {1'b0, {MW{1'b1}}};
    end else begin
      mag = shifted;
    end
    smp_d = s3_sgn_q ? ('0 - mag) : mag;
  end

  always_ff @(posedge clk) begin
    if (load[0]) begin
      s1_sgn_q  <= code[SW-1];
      s1_zero_q <= (code[MW-1:0] == '1);
      s1_fld_q  <= code[MW-1:0];
    end
    if (load[1]) begin
      s2_log_q  <= s2_log_d;
      s2_sgn_q  <= s1_sgn_q;
      s2_zero_q <= s1_zero_q;
    end
    if (load[2]) begin
      s3_oct_q  <= s3_oct_d;
      s3_man_q  <= s3_man_d;
      s3_sgn_q  <= s2_sgn_q;
      s3_zero_q <= s2_zero_q;
    end
    if (load[3]) begin
      smp_q <= smp_d;
    end
  end

  assign smp = smp_q;
endmodule

// File: rtl/logiq_codec.sv
module logiq_codec
  import logiq_pkg::*;
#(
  parameter int SAMPLE_W = LQ_SAMPLE_W,
  parameter int FRAC_W   = LQ_FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enc_in_valid,
  output logic                enc_in_ready,
  input  logic [SAMPLE_W-1:0] enc_in_i,
  input  logic [SAMPLE_W-1:0] enc_in_q,
  input  logic [SAMPLE_W-1:0] enc_gain,
  output logic                enc_out_valid,
  input  logic                enc_out_ready,
  output logic [SAMPLE_W-1:0] enc_out_i,
  output logic [SAMPLE_W-1:0] enc_out_q,
  input  logic                dec_in_valid,
  output logic                dec_in_ready,
  input  logic [SAMPLE_W-1:0] dec_in_i,
  input  logic [SAMPLE_W-1:0] dec_in_q,
  output logic                dec_out_valid,
  input  logic                dec_out_ready,
  output logic [SAMPLE_W-1:0] dec_out_i,
  output logic [SAMPLE_W-1:0] dec_out_q
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_d, rst_sync_q;
  logic       rst_int_n;

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LQ_STAGES-1:0] enc_load, dec_load;

  logiq_pipe_ctrl #(.STAGES(LQ_STAGES)) enc_ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (enc_in_valid),
    .out_ready (enc_out_ready),
    .in_ready  (enc_in_ready),
    .out_valid (enc_out_valid),
    .load      (enc_load)
  );

  logiq_pipe_ctrl #(.STAGES(LQ_STAGES)) dec_ctrl_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (dec_in_valid),
    .out_ready (dec_out_ready),
    .in_ready  (dec_in_ready),
    .out_valid (dec_out_valid),
    .load      (dec_load)
  );

  logic [SAMPLE_W-1:0] enc_x [LQ_LANES];
  logic [SAMPLE_W-1:0] enc_c [LQ_LANES];
  logic [SAMPLE_W-1:0] dec_c [LQ_LANES];
  logic [SAMPLE_W-1:0] dec_y [LQ_LANES];

  assign enc_x[int'(LANE_I)] = enc_in_i;
  assign enc_x[int'(LANE_Q)] = enc_in_q;
  assign dec_c[int'(LANE_I)] = dec_in_i;
  assign dec_c[int'(LANE_Q)] = dec_in_q;

  for (genvar ln = 0; ln < LQ_LANES; ln++) begin : g_lane
    logiq_enc_lane #(.SW(SAMPLE_W), .FW(FRAC_W)) enc_lane_i (
      .clk  (clk),
      .load (enc_load),
      .smp  (enc_x[ln]),
      .gain (enc_gain),
      .code (enc_c[ln])
    );
    logiq_dec_lane #(.SW(SAMPLE_W), .FW(FRAC_W)) dec_lane_i (
      .clk  (clk),
      .load (dec_load),
      .code (dec_c[ln]),
      .smp  (dec_y[ln])
    );
  end

  assign enc_out_i = enc_c[int'(LANE_I)];
  assign enc_out_q = enc_c[int'(LANE_Q)];
  assign dec_out_i = dec_y[int'(LANE_I)];
  assign dec_out_q = dec_y[int'(LANE_Q)];
endmodule

// File: rtl/logiq_codec_chk.sv
module logiq_codec_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enc_in_ready,
  input logic                enc_out_valid,
  input logic                enc_out_ready,
  input logic [SAMPLE_W-1:0] enc_out_i,
  input logic [SAMPLE_W-1:0] enc_out_q,
  input logic                dec_in_ready,
  input logic                dec_out_valid,
  input logic                dec_out_ready,
  input logic [SAMPLE_W-1:0] dec_out_i,
  input logic [SAMPLE_W-1:0] dec_out_q
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  assert_enc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_i) && $stable(enc_out_q));

  assert_dec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_i) && $stable(dec_out_q));

  assert_enc_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enc_out_valid && !enc_out_ready |-> !enc_in_ready);

  assert_dec_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |-> !dec_in_ready);

  assert_dec_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid |-> (dec_out_i != MOST_NEG) && (dec_out_q != MOST_NEG));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R11: assert (!enc_out_valid && !dec_out_valid);
    end
  end
endmodule

bind logiq_codec logiq_codec_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .enc_in_ready  (enc_in_ready),
  .enc_out_valid (enc_out_valid),
  .enc_out_ready (enc_out_ready),
  .enc_out_i     (enc_out_i),
  .enc_out_q     (enc_out_q),
  .dec_in_ready  (dec_in_ready),
  .dec_out_valid (dec_out_valid),
  .dec_out_ready (dec_out_ready),
  .dec_out_i     (dec_out_i),
  .dec_out_q     (dec_out_q)
);

// File: tb/logiq_codec_tb.sv
module logiq_codec_tb_top;
  logic        clk;
  logic        rst_n;
  logic        enc_in_valid, enc_in_ready, enc_out_valid, enc_out_ready;
  logic [15:0] enc_in_i, enc_in_q, enc_gain, enc_out_i, enc_out_q;
  logic        dec_in_valid, dec_in_ready, dec_out_valid, dec_out_ready;
  logic [15:0] dec_in_i, dec_in_q, dec_out_i, dec_out_q;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct {
    logic [15:0] i;
    logic [15:0] q;
    int          x;
    string       tag;
  } exp_t;

  exp_t        eq[$];
  logic [15:0] rt_code [2048];

  logiq_codec dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] enc_model(input logic [15:0] x, input int g);
    int a, p, m, d;
    logic s;
    if (x == 16'h0000) return 16'h7FFF;
    s = x[15];
    a = s ? (65536 - int'(x)) : int'(x);
    if (a > 32767) a = 32767;
    p = 0;
    for (int b = 0; b < 15; b++) if (((a >> b) & 1) == 1) p = b;
    m = (p >= 8) ? ((a >> (p - 8)) & 255) : ((a << (8 - p)) & 255);
    d = 3 * ((15 - p) * 256 - m) + g;
    if (d < 0) d = 0;
    if (d > 32767) d = 32767;
    return {s, d[14:0]};
  endfunction

  function automatic logic [15:0] dec_model(input logic [15:0] c);
    int d, l, n, f, mag;
    d = int'(c[14:0]);
    if (d == 32767) return 16'h0000;
    l = d / 3;
    n = l / 256;
    f = l % 256;
    mag = (n >= 16) ? 0 : (((512 - f) * 64) >> n);
    if (mag > 32767) mag = 32767;
    return c[15] ? 16'(-mag) : 16'(mag);
  endfunction

  function automatic logic [15:0] rt_model(input logic [15:0] x);
    int a, p;
    if (x == 16'h0000) return 16'h0000;
    a = x[15] ? (65536 - int'(x)) : int'(x);
    if (a > 32767) a = 32767;
    p = 0;
    for (int b = 0; b < 15; b++) if (((a >> b) & 1) == 1) p = b;
    if (p >= 8) a = (a >> (p - 8)) << (p - 8);
    return x[15] ? 16'(-a) : 16'(a);
  endfunction

  function automatic int gain_pick(input int k);
    case (k % 8)
      0: return 300;
      1: return -300;
      2: return 32767;
      3: return -32768;
      4: return 20000;
      5: return -11520;
      6: return 1000;
      default: return -5;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode 0: sweep, 1: gain sweep, 2: random with backpressure
  task automatic run_enc(input int mode, input int count);
    int   sent = 0;
    bit   pend = 0;
    exp_t cur;
    while (sent < count || eq.size() > 0) begin
      @(negedge clk);
      enc_out_ready = (mode == 2) ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (!pend && sent < count) begin
        logic [15:0] x, xq;
        int g;
        if (mode == 0) begin
          x = 16'(sent); xq = x ^ 16'hA5C3; g = 0;
        end else if (mode == 1) begin
          x = 16'(sent * 37); if (sent % 64 == 0) x = 16'h0000;
          xq = x ^ 16'h8000; g = gain_pick(sent);
        end else begin
          x = 16'($urandom); xq = 16'($urandom); g = int'($signed(16'($urandom)));
        end
        enc_in_i = x; enc_in_q = xq; enc_gain = 16'(g);
        cur.i = enc_model(x, g); cur.q = enc_model(xq, g); cur.x = int'(x);
        if (mode == 2) cur.tag = "R10 stream";
        else if (mode == 1) cur.tag = (x == 0) ? "R4 zero with gain" : "R5 gain clamp";
        else if (x == 16'h8000) cur.tag = "R3 minus one";
        else if (x == 16'h0000) cur.tag = "R4 zero";
        else cur.tag = "R1 R2 code";
        enc_in_valid = 1'b1; pend = 1;
      end else if (!pend) begin
        enc_in_valid = 1'b0;
      end
      #1;
      if (enc_out_valid && enc_out_ready) begin
        if (eq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: actual extra output expected none");
        end else begin
          exp_t e = eq.pop_front();
          check(e.tag, enc_out_i, e.i);
          check({e.tag, " R6 Q lane"}, enc_out_q, e.q);
          if (mode == 0 && (e.x % 32) == 0) rt_code[e.x / 32] = enc_out_i;
        end
      end
      if (enc_in_valid && enc_in_ready) begin
        eq.push_back(cur); sent++; pend = 0;
      end
    end
    @(negedge clk);
    enc_in_valid = 1'b0;
  endtask

  // mode 0: all codes, 1: round trip, 2: random with backpressure
  task automatic run_dec(input int mode, input int count);
    int   sent = 0;
    bit   pend = 0;
    exp_t cur;
    while (sent < count || eq.size() > 0) begin
      @(negedge clk);
      dec_out_ready = (mode == 2) ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (!pend && sent < count) begin
        logic [15:0] c, cq;
        if (mode == 0) begin
          c = 16'(sent); cq = ~c;
          cur.i = dec_model(c); cur.q = dec_model(cq); cur.tag = "R7 expand";
        end else if (mode == 1) begin
          c = rt_code[sent]; cq = c;
          cur.i = rt_model(16'(sent * 32)); cur.q = cur.i; cur.tag = "R8 round trip";
        end else begin
          c = 16'($urandom); cq = 16'($urandom);
          cur.i = dec_model(c); cur.q = dec_model(cq); cur.tag = "R10 stream";
        end
        dec_in_i = c; dec_in_q = cq;
        dec_in_valid = 1'b1; pend = 1;
      end else if (!pend) begin
        dec_in_valid = 1'b0;
      end
      #1;
      if (dec_out_valid && dec_out_ready) begin
        if (eq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: actual extra output expected none");
        end else begin
          exp_t e = eq.pop_front();
          check(e.tag, dec_out_i, e.i);
          check({e.tag, " R6 Q lane"}, dec_out_q, e.q);
        end
      end
      if (dec_in_valid && dec_in_ready) begin
        eq.push_back(cur); sent++; pend = 0;
      end
    end
    @(negedge clk);
    dec_in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b1;
    enc_in_valid = 0; enc_out_ready = 1; enc_in_i = 0; enc_in_q = 0; enc_gain = 0;
    dec_in_valid = 0; dec_out_ready = 1; dec_in_i = 0; dec_in_q = 0;
    #1 rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R11 reset enc valid", {15'd0, enc_out_valid}, 16'd0);
      check("R11 reset dec valid", {15'd0, dec_out_valid}, 16'd0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R11 idle enc valid", {15'd0, enc_out_valid}, 16'd0);
      check("R11 idle dec valid", {15'd0, dec_out_valid}, 16'd0);
    end

    // R9 latency, both directions driven on the same edge
    @(negedge clk);
    enc_in_i = 16'h1234; enc_in_q = 16'hC000; enc_gain = 16'd0; enc_in_valid = 1'b1;
    dec_in_i = 16'h0300; dec_in_q = 16'h8000; dec_in_valid = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      enc_in_valid = 1'b0; dec_in_valid = 1'b0;
      check("R9 enc latency", {15'd0, enc_out_valid}, (k == 4) ? 16'd1 : 16'd0);
      check("R9 dec latency", {15'd0, dec_out_valid}, (k == 4) ? 16'd1 : 16'd0);
    end
    check("R9 enc data", enc_out_i, enc_model(16'h1234, 0));
    check("R9 enc data q", enc_out_q, enc_model(16'hC000, 0));
    check("R9 dec data", dec_out_i, dec_model(16'h0300));
    check("R9 dec data q", dec_out_q, dec_model(16'h8000));
    repeat (2) @(negedge clk);

    run_enc(0, 65536);
    run_enc(1, 6000);
    run_enc(2, 2000);
    enc_out_ready = 1'b1;
    run_dec(0, 65536);
    run_dec(1, 2048);
    run_dec(2, 2000);
    dec_out_ready = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule